// File: doc/BRIEF.md
# Display Controller Status and Interrupt Register

This block keeps the event record of a display controller and drives the controller's single interrupt request line. Pulses from the surrounding hardware report these events: overrun and underrun on the input and output pixel FIFOs, the bias-pin toggle counter reaching its limit, a DMA bus error, and a completed shutdown. Most of these events are latched in sticky bits, which software clears by writing a one. The base-ready indication is different. It is a read-only flag that the DMA hardware alone sets and clears: a base-to-current address transfer sets it, and a write to the base address register clears it.

Two small state machines carry the timing rules. The drain tracker has the states OFF, RUN and DRAIN. The transition OFF→RUN happens when the enable rises. RUN→DRAIN happens when the enable falls. DRAIN→RUN (cancel) happens when the enable returns before the frame ends. DRAIN→OFF (done) happens on the end-of-frame pulse, and only this transition sets the disable-done bit. The base tracker has the states EMPTY, HALF_A, HALF_B and READY. In single-panel mode the transition EMPTY→READY happens on a channel A load. In dual-panel mode the transitions EMPTY→HALF_A and EMPTY→HALF_B record the first channel to load. HALF_A→READY and HALF_B→READY happen when the other channel loads, and EMPTY→READY happens when both channels load in the same cycle. READY→EMPTY happens on a write to the base register that clears the flag. A mask register gates each bit. The OR of all pending bits that are not masked goes through a flop to give the interrupt output.

Top module: `dpy_status_irq`

## Requirements
- R1: After reset the status register (address 0) reads 0, the mask register (address 1) reads 0x00FF (all events masked), and `irq` is 0.
- R2: Sticky bits are set by a one-cycle event pulse and read 1 from the cycle after that pulse until software clears them. The bit positions are: 0 disable-done, 2 bus error, 3 input overrun, 4 input underrun, 5 output overrun, 6 output underrun, 7 bias count.
- R3: A write to address 0 clears each sticky bit written with 1. Bits written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Bit 1 (base ready) ignores register writes. In single-panel mode a channel A load sets it, and only a channel A base write clears it.
- R6: In dual-panel mode bit 1 is set only after both channels have loaded, in either order or in the same cycle. Only a channel B base write clears it.
- R7: Disable-done (bit 0) is set by an end-of-frame pulse only while draining, that is after the enable has fallen. It is not set when the enable falls, by an end-of-frame pulse while running or off, or after the enable returns before the frame ends.
- R8: `irq` is 1 in the cycle after any status bit is 1 while its mask bit is 0, and 0 in the cycle after no such bit exists.
- R9: Address 1 reads back the low 8 mask bits written to it. Bits above 7 and the unused addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ev_in_ovr | input | 1 | Input FIFO overrun pulse |
| ev_in_udr | input | 1 | Input FIFO underrun pulse |
| ev_out_ovr | input | 1 | Output FIFO overrun pulse |
| ev_out_udr | input | 1 | Output FIFO underrun pulse |
| ev_bias_hit | input | 1 | Bias toggle count reached pulse |
| ev_bus_err | input | 1 | DMA bus error pulse |
| ctl_enable | input | 1 | Controller enable level |
| frame_end | input | 1 | Last pixels of the frame clocked out |
| dual_panel | input | 1 | Dual-panel mode level |
| base_a_load | input | 1 | Channel A base copied to current address |
| base_b_load | input | 1 | Channel B base copied to current address |
| base_a_wr | input | 1 | Channel A base register written |
| base_b_wr | input | 1 | Channel B base register written |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest situation to reach from the ports is the DRAIN state: the enable has fallen but the frame has not ended, and the controller must not report done yet. The stimulus first walks OFF→RUN→DRAIN and checks that the status stays zero. It then sends the end-of-frame pulse to reach the done transition, and separately re-raises the enable inside DRAIN to show that the cancel path suppresses the bit. The same-cycle collision of a clearing write with an event pulse, and the two orders of dual-panel loads, are driven on purpose within a single cycle each.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
    localparam int NBITS  = 8;
    localparam int B_DONE = 0;
    localparam int B_BASE = 1;
    localparam int B_BERR = 2;
    localparam int B_IOVR = 3;
    localparam int B_IUDR = 4;
    localparam int B_OOVR = 5;
    localparam int B_OUDR = 6;
    localparam int B_BIAS = 7;

    typedef enum logic [1:0] {
        DR_OFF   = 2'd0,
        DR_RUN   = 2'd1,
        DR_DRAIN = 2'd2
    } drain_st_t;

    typedef enum logic [1:0] {
        BF_EMPTY  = 2'd0,
        BF_HALF_A = 2'd1,
        BF_HALF_B = 2'd2,
        BF_READY  = 2'd3
    } base_st_t;
endpackage

// File: rtl/dsi_sticky_bit.sv
module dsi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end

    assign q_o = q;

    // R4: hardware set beats a same-cycle clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R2: bit holds until a clear arrives
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    // R3: a clear without a set empties the bit
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/dsi_drain_fsm.sv
module dsi_drain_fsm
    import dsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic frame_end_i,
    output logic done_o
);
    drain_st_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DR_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        done_o   = 1'b0;
        unique case (state)
            DR_OFF: begin
                if (enable_i) state_nx = DR_RUN;
            end
            DR_RUN: begin
                if (!enable_i) state_nx = DR_DRAIN;
            end
            DR_DRAIN: begin
                if (enable_i) begin
                    state_nx = DR_RUN;
                end else if (frame_end_i) begin
                    state_nx = DR_OFF;
                    done_o   = 1'b1;
                end
            end
            default: state_nx = DR_OFF;
        endcase
    end

    // R7: draining is only entered with the enable low
    assert_drain_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DR_DRAIN) |-> !$past(enable_i));
    // R7: done leaves the controller off
    assert_done_to_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state == DR_OFF));
    // R7: frame end while running never reports done
    assert_no_done_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DR_DRAIN) |-> !done_o);
endmodule

// File: rtl/dsi_base_flag.sv
module dsi_base_flag
    import dsi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dual_i,
    input  logic load_a_i,
    input  logic load_b_i,
    input  logic wr_a_i,
    input  logic wr_b_i,
    output logic flag_o
);
    base_st_t state, state_nx;
    logic     clr;

    assign clr = dual_i ? wr_b_i : wr_a_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BF_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BF_EMPTY: begin
                if (!dual_i) begin
                    if (load_a_i) state_nx = BF_READY;
                end else if (load_a_i && load_b_i) begin
                    state_nx = BF_READY;
                end else if (load_a_i) begin
                    state_nx = BF_HALF_A;
                end else if (load_b_i) begin
                    state_nx = BF_HALF_B;
                end
            end
            BF_HALF_A: begin
                if (load_b_i || (!dual_i && load_a_i)) state_nx = BF_READY;
            end
            BF_HALF_B: begin
                if (load_a_i) state_nx = BF_READY;
            end
            BF_READY: begin
                if (clr) state_nx = BF_EMPTY;
            end
            default: state_nx = BF_EMPTY;
        endcase
    end

    assign flag_o = (state == BF_READY);

    // R6: one dual-panel load alone never raises the flag
    assert_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BF_EMPTY && dual_i && !(load_a_i && load_b_i)) |=> !flag_o);
    // R5: flag persists without its hardware clear
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);
endmodule

// File: rtl/dpy_status_irq.sv
module dpy_status_irq
    import dsi_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int ADDR_STATUS = 0,
    parameter int ADDR_MASK   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_in_ovr,
    input  logic              ev_in_udr,
    input  logic              ev_out_ovr,
    input  logic              ev_out_udr,
    input  logic              ev_bias_hit,
    input  logic              ev_bus_err,
    input  logic              ctl_enable,
    input  logic              frame_end,
    input  logic              dual_panel,
    input  logic              base_a_load,
    input  logic              base_b_load,
    input  logic              base_a_wr,
    input  logic              base_b_wr,
    output logic              irq
);
    localparam int NB = NBITS;

    logic [NB-1:0] status;
    logic [NB-1:0] set_vec;
    logic [NB-1:0] clr_vec;
    logic [NB-1:0] mask_q;
    logic [NB-1:0] pending;
    logic          done_pulse;
    logic          base_flag;
    logic          irq_q;
    logic          wr_status;
    logic          wr_mask;
    logic          unused_bits;

    assign wr_status = reg_wr && (reg_addr == ADDR_W'(ADDR_STATUS));
    assign wr_mask   = reg_wr && (reg_addr == ADDR_W'(ADDR_MASK));
    assign clr_vec   = wr_status ? reg_wdata[NB-1:0] : '0;

    always_comb begin
        set_vec         = '0;
        set_vec[B_DONE] = done_pulse;
        set_vec[B_BERR] = ev_bus_err;
        set_vec[B_IOVR] = ev_in_ovr;
        set_vec[B_IUDR] = ev_in_udr;
        set_vec[B_OOVR] = ev_out_ovr;
        set_vec[B_OUDR] = ev_out_udr;
        set_vec[B_BIAS] = ev_bias_hit;
    end

    assign unused_bits = ^{reg_wdata[DATA_W-1:NB], clr_vec[B_BASE], set_vec[B_BASE]};

    dsi_drain_fsm u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (ctl_enable),
        .frame_end_i (frame_end),
        .done_o      (done_pulse)
    );

    dsi_base_flag u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual_i   (dual_panel),
        .load_a_i (base_a_load),
        .load_b_i (base_b_load),
        .wr_a_i   (base_a_wr),
        .wr_b_i   (base_b_wr),
        .flag_o   (base_flag)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bit
        if (g == B_BASE) begin : g_flag
            assign status[g] = base_flag;
        end else begin : g_sticky
            dsi_sticky_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[g]),
                .clr_i (clr_vec[g]),
                .q_o   (status[g])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= reg_wdata[NB-1:0];
    end

    assign pending = status & ~mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pending;
    end

    assign irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_STATUS))    reg_rdata[NB-1:0] = status;
        else if (reg_addr == ADDR_W'(ADDR_MASK)) reg_rdata[NB-1:0] = mask_q;
    end

    // R8: nothing pending means no request next cycle
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq);
    // R8: a fully masked register never requests
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |=> !irq);
    // R5: a status write leaves the base flag alone
    assert_base_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && base_flag && !base_a_wr && !base_b_wr) |=> status[B_BASE]);
    // R9: unused addresses read zero
    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADDR_W'(ADDR_MASK)) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_dpy_status_irq.sv
module sim_dpy_status_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [10:0] ev = '0;
    logic        ctl_enable = 1'b0;
    logic        dual_panel = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic [1:0]  addr;
        logic [15:0] rd;
        logic        irq_v;
        bit          irq_care;
        string       req;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    dpy_status_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_in_ovr(ev[0]), .ev_in_udr(ev[1]), .ev_out_ovr(ev[2]),
        .ev_out_udr(ev[3]), .ev_bias_hit(ev[4]), .ev_bus_err(ev[5]),
        .ctl_enable(ctl_enable), .frame_end(ev[6]), .dual_panel(dual_panel),
        .base_a_load(ev[7]), .base_b_load(ev[8]),
        .base_a_wr(ev[9]), .base_b_wr(ev[10]), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (reg_rdata !== it.rd) begin
                errors++;
                $display("FAIL %s addr %0d rdata actual %h expected %h", it.req, it.addr, reg_rdata, it.rd);
            end
            if (it.irq_care) begin
                checks++;
                if (irq !== it.irq_v) begin
                    errors++;
                    $display("FAIL %s irq actual %b expected %b", it.req, irq, it.irq_v);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse(input logic [10:0] m);
        ev = m; tick(); ev = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [15:0] d,
                             input bit care, input logic iv, input string req);
        item_t it;
        reg_addr = a;
        it.addr = a; it.rd = d; it.irq_v = iv; it.irq_care = care; it.req = req;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        #3_000_000;
        if (!done_run) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_rd(0, 16'h0000, 1, 0, "R1");
        expect_rd(1, 16'h00FF, 1, 0, "R1");
        // R9 mask register and unused addresses; unmask bits 0..3
        wr(1, 16'hFFF0);
        expect_rd(1, 16'h00F0, 0, 0, "R9");
        expect_rd(2, 16'h0000, 0, 0, "R9");
        expect_rd(3, 16'h0000, 0, 0, "R9");
        // R2 bus error sets bit 2; R8 irq follows one cycle later
        pulse(11'h020);
        expect_rd(0, 16'h0004, 1, 0, "R2");
        tick();
        expect_rd(0, 16'h0004, 1, 1, "R8");
        // R3 zero write no effect, one write clears
        wr(0, 16'h0000);
        expect_rd(0, 16'h0004, 1, 1, "R3");
        wr(0, 16'h0004);
        expect_rd(0, 16'h0000, 1, 1, "R3");
        tick();
        expect_rd(0, 16'h0000, 1, 0, "R8");
        // R8 masked bit (output underrun, bit 6) raises no request
        pulse(11'h008);
        tick();
        expect_rd(0, 16'h0040, 1, 0, "R8");
        wr(0, 16'h0040);
        // R4 set and clear of input overrun in the same cycle
        reg_addr = 0; reg_wdata = 16'h0008; reg_wr = 1'b1;
        pulse(11'h001);
        reg_wr = 1'b0;
        expect_rd(0, 16'h0008, 0, 0, "R4");
        wr(0, 16'h0008);
        tick();
        expect_rd(0, 16'h0000, 1, 0, "R4");
        // R2 remaining sticky bits together
        pulse(11'h016);
        expect_rd(0, 16'h00B0, 0, 0, "R2");
        wr(0, 16'hFFFF);
        expect_rd(0, 16'h0000, 0, 0, "R3");
        // R5 single-panel base flag
        dual_panel = 1'b0;
        pulse(11'h080);
        expect_rd(0, 16'h0002, 0, 0, "R5");
        wr(0, 16'h0002);
        expect_rd(0, 16'h0002, 0, 0, "R5");
        pulse(11'h400);
        expect_rd(0, 16'h0002, 0, 0, "R5");
        pulse(11'h200);
        expect_rd(0, 16'h0000, 0, 0, "R5");
        // R6 dual-panel: A then B, clear by B write only
        dual_panel = 1'b1;
        pulse(11'h080);
        expect_rd(0, 16'h0000, 0, 0, "R6");
        pulse(11'h100);
        expect_rd(0, 16'h0002, 0, 0, "R6");
        pulse(11'h200);
        expect_rd(0, 16'h0002, 0, 0, "R6");
        pulse(11'h400);
        expect_rd(0, 16'h0000, 0, 0, "R6");
        // R6 B first, then A
        pulse(11'h100);
        expect_rd(0, 16'h0000, 0, 0, "R6");
        pulse(11'h080);
        expect_rd(0, 16'h0002, 0, 0, "R6");
        pulse(11'h400);
        // R6 both in one cycle
        pulse(11'h180);
        expect_rd(0, 16'h0002, 0, 0, "R6");
        pulse(11'h400);
        expect_rd(0, 16'h0000, 0, 0, "R6");
        dual_panel = 1'b0;
        tick();
        // R7 frame end while off or running does nothing
        pulse(11'h040);
        expect_rd(0, 16'h0000, 0, 0, "R7");
        ctl_enable = 1'b1; tick();
        pulse(11'h040);
        expect_rd(0, 16'h0000, 0, 0, "R7");
        // R7 enable falls: not yet done
        ctl_enable = 1'b0; tick();
        tick();
        expect_rd(0, 16'h0000, 1, 0, "R7");
        pulse(11'h040);
        expect_rd(0, 16'h0001, 1, 0, "R7");
        tick();
        expect_rd(0, 16'h0001, 1, 1, "R8");
        wr(0, 16'h0001);
        tick();
        // R7 cancel: enable returns during drain
        ctl_enable = 1'b1; tick();
        ctl_enable = 1'b0; tick();
        ctl_enable = 1'b1; tick();
        pulse(11'h040);
        expect_rd(0, 16'h0000, 1, 0, "R7");
        ctl_enable = 1'b0; tick();
        pulse(11'h040);
        expect_rd(0, 16'h0001, 0, 0, "R7");
        tick();
        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule